// File: doc/BRIEF.md
# Reconfiguration Trigger and Error Controller

This block chooses the configuration image that a programmable device loads next, once an error or an explicit reload request has been seen. Five request sources feed it: an external reset request, a status-pin error, a reload strobe from the user core, a CRC error flag and a watchdog timeout. Each one is a single-bit input sampled on every clock. When the block is idle and any source is high, the block accepts the request. It writes the cause into a status register. It loads a control register, either with zeros or with the contents of a user-writable update register. One cycle later it raises a reload request that stays high for a fixed, parameterised number of cycles.

The control register is cleared for every error cause. It takes the update register only when the user core asked for the reload. The next image is the factory image after any error. A core-requested reload starts the application image when the device currently runs the factory image, and returns to the factory image when it currently runs an application. The reload request lasts `PULSE_CYC` cycles. At a 50 MHz clock the default of 13 cycles gives 260 ns, which meets the 250 ns minimum the configuration logic needs. While a reload is in progress, further requests are ignored.

Top module: `recfg_trigger_ctrl`

## Requirements
- R1: After reset, `ctrl_reg`, `status_reg`, `image_sel`, `reconfig_req` and `busy` are all 0.
- R2: An accepted external reset request, status error, CRC error or watchdog timeout clears every bit of `ctrl_reg` to 0.
- R3: An accepted core reload request loads `ctrl_reg` with the value of `upd_reg` in the acceptance cycle.
- R4: `status_reg` holds exactly one set bit after an accepted request, naming its cause: bit 0 external reset, bit 1 status error, bit 2 core request, bit 3 CRC error, bit 4 watchdog timeout.
- R5: When several sources are high together, only one is accepted, in the priority order external reset, CRC error, status error, watchdog timeout, core request.
- R6: A request is accepted on the clock edge where `busy` is low and a source is high. `status_reg` and `ctrl_reg` take their new values at that edge. `reconfig_req` rises one clock later, so the cause is recorded before the image is launched.
- R7: `reconfig_req` stays high for exactly `PULSE_CYC` consecutive cycles per accepted request.
- R8: `busy` is high from the acceptance edge until `reconfig_req` falls, which is `PULSE_CYC`+1 cycles in all.
- R9: Sources and `upd_reg` have no effect while `busy` is high: `status_reg` and `ctrl_reg` keep their values.
- R10: During `reconfig_req`, `image_sel` (1 = application, 0 = factory) is 0 for any error cause. For a core request it is 1 if `app_mode` was 0 at acceptance, and 0 if `app_mode` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_reset_req | input | 1 | External reset request |
| stat_err | input | 1 | Status-pin error flag |
| core_reload | input | 1 | Reload strobe from the user core |
| crc_err | input | 1 | CRC error flag |
| wd_timeout | input | 1 | Watchdog timeout flag |
| app_mode | input | 1 | Current image: 1 application, 0 factory |
| upd_reg | input | CTRL_W | User update register contents |
| ctrl_reg | output | CTRL_W | Control register (image address and settings) |
| status_reg | output | 5 | One-hot cause of the last accepted request |
| image_sel | output | 1 | Next image: 1 application, 0 factory |
| reconfig_req | output | 1 | Reload request pulse |
| busy | output | 1 | Reload in progress |

## Verification
The assertions check several properties on every cycle: the request pulse lies inside the busy window, the pulse width equals the parameter, the status register stays one-hot, and both registers hold still while busy. They also check that the request rises only after a cycle of busy, and that error causes never point at the application image. Other behaviours can only be shown by the bench's sweep over every combination of sources in both modes: the priority winner, the values written into the registers, the mode-dependent image choice, and the fact that requests held during busy are dropped rather than queued.

// File: rtl/recfg_pkg.sv
// Package: shared cause encoding and priority order for the
// reconfiguration trigger controller. Assumes five causes.
package recfg_pkg;

    localparam int NUM_CAUSES = 5;

    // Bit positions in the cause vector and the status register.
    localparam int C_EXT  = 0;
    localparam int C_STAT = 1;
    localparam int C_CORE = 2;
    localparam int C_CRC  = 3;
    localparam int C_WD   = 4;

    // Arbitration order, highest priority first (R5).
    localparam int PRIO [NUM_CAUSES] = '{C_EXT, C_CRC, C_STAT, C_WD, C_CORE};

    // Mask of the causes that count as errors.
    localparam logic [NUM_CAUSES-1:0] ERR_MASK =
        NUM_CAUSES'((1 << C_EXT) | (1 << C_STAT) | (1 << C_CRC) | (1 << C_WD));

endpackage

// File: rtl/recfg_arbiter.sv
// Module: recfg_arbiter
// Picks one cause out of the raw source vector by fixed priority.
// Purely combinational. Assumes the sources are already synchronous.
module recfg_arbiter
    import recfg_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] src_vec,
    output logic                  hit,
    output logic [NUM_CAUSES-1:0] grant
);

    // Walk from lowest to highest priority so the top one wins.
    always_comb begin
        grant = '0;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (src_vec[PRIO[i]]) begin
                grant          = '0;
                grant[PRIO[i]] = 1'b1;
            end
        end
    end

    // Any source present.
    always_comb hit = |src_vec;

endmodule

// File: rtl/recfg_pulse.sv
// Module: recfg_pulse
// Sequencer: one record cycle after acceptance, then a request pulse
// of exactly PULSE_CYC cycles. Assumes PULSE_CYC >= 1.
module recfg_pulse #(
    parameter int PULSE_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic busy,
    output logic launch,
    output logic req
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_RECORD, S_PULSE} seq_t;

    seq_t             state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_cnt;

    // State and countdown for the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                S_IDLE:   if (accept) state <= S_RECORD;
                S_RECORD: begin
                    state <= S_PULSE;
                    cnt   <= CNT_W'(PULSE_CYC - 1);
                end
                S_PULSE: begin
                    if (cnt == '0) state <= S_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Decoded outputs.
    always_comb begin
        busy   = (state != S_IDLE);
        launch = (state == S_RECORD);
        req    = (state == S_PULSE);
    end

    // Independent width counter, used only by the width check below.
    always_ff @(posedge clk) begin
        if (!rst_n || !req) hi_cnt <= '0;
        else                hi_cnt <= hi_cnt + 1'b1;
    end

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (hi_cnt == CNT_W'(PULSE_CYC)));

    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);

endmodule

// File: rtl/recfg_regs.sv
// Module: recfg_regs
// Control, status and image-select registers. Written on acceptance;
// image_sel is updated when the pulse is launched.
module recfg_regs
    import recfg_pkg::*;
#(
    parameter int CTRL_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  launch,
    input  logic [NUM_CAUSES-1:0] grant,
    input  logic [CTRL_W-1:0]     upd,
    input  logic                  app_mode,
    output logic [CTRL_W-1:0]     ctrl,
    output logic [NUM_CAUSES-1:0] status,
    output logic                  image_sel
);

    logic app_pending;

    // Record cause and control word at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl        <= '0;
            status      <= '0;
            app_pending <= 1'b0;
        end else if (accept) begin
            status      <= grant;
            ctrl        <= grant[C_CORE] ? upd : '0;
            app_pending <= grant[C_CORE] & ~app_mode;
        end
    end

    // Commit the image choice once the cause is recorded.
    always_ff @(posedge clk) begin
        if (!rst_n)      image_sel <= 1'b0;
        else if (launch) image_sel <= app_pending;
    end

    // R4
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

endmodule

// File: rtl/recfg_trigger_ctrl.sv
// Module: recfg_trigger_ctrl (top)
// Accepts one of five reload causes when idle, records it, loads the
// control register and issues a stretched reload request.
// Assumes all source inputs are synchronous to clk.
module recfg_trigger_ctrl
    import recfg_pkg::*;
#(
    parameter int CTRL_W    = 24,
    parameter int PULSE_CYC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_reset_req,
    input  logic              stat_err,
    input  logic              core_reload,
    input  logic              crc_err,
    input  logic              wd_timeout,
    input  logic              app_mode,
    input  logic [CTRL_W-1:0] upd_reg,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [4:0]        status_reg,
    output logic              image_sel,
    output logic              reconfig_req,
    output logic              busy
);

    logic [NUM_CAUSES-1:0] src_vec;
    logic [NUM_CAUSES-1:0] grant;
    logic                  hit;
    logic                  accept;
    logic                  launch;

    // Gather sources into cause-indexed vector.
    always_comb begin
        src_vec         = '0;
        src_vec[C_EXT]  = ext_reset_req;
        src_vec[C_STAT] = stat_err;
        src_vec[C_CORE] = core_reload;
        src_vec[C_CRC]  = crc_err;
        src_vec[C_WD]   = wd_timeout;
    end

    // Accept only when idle.
    always_comb accept = hit & ~busy;

    recfg_arbiter u_arb (
        .src_vec (src_vec),
        .hit     (hit),
        .grant   (grant)
    );

    recfg_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .busy   (busy),
        .launch (launch),
        .req    (reconfig_req)
    );

    recfg_regs #(.CTRL_W(CTRL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .launch    (launch),
        .grant     (grant),
        .upd       (upd_reg),
        .app_mode  (app_mode),
        .ctrl      (ctrl_reg),
        .status    (status_reg),
        .image_sel (image_sel)
    );

    // R6
    record_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconfig_req) |-> ($past(busy) && $stable(status_reg)));

    // R9
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctrl_reg) && $stable(status_reg)));

    // R10
    error_to_factory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconfig_req && |(status_reg & ERR_MASK)) |-> !image_sel);

    // R2
    error_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && |(status_reg & ERR_MASK)) |-> (ctrl_reg == '0));

endmodule

// File: tb/tb_recfg_trigger_ctrl.sv
// Bench: sweeps every source combination in both modes on a short pulse.
module tb_recfg_trigger_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int PC         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_reset_req = 0, stat_err = 0, core_reload = 0;
    logic          crc_err = 0, wd_timeout = 0, app_mode = 0;
    logic [CW-1:0] upd_reg = '0;
    logic [CW-1:0] ctrl_reg;
    logic [4:0]    status_reg;
    logic          image_sel, reconfig_req, busy;

    int n_vec  = 0;
    int n_fail = 0;

    recfg_trigger_ctrl #(.CTRL_W(CW), .PULSE_CYC(PC)) dut (
        .clk(clk), .rst_n(rst_n), .ext_reset_req(ext_reset_req),
        .stat_err(stat_err), .core_reload(core_reload), .crc_err(crc_err),
        .wd_timeout(wd_timeout), .app_mode(app_mode), .upd_reg(upd_reg),
        .ctrl_reg(ctrl_reg), .status_reg(status_reg), .image_sel(image_sel),
        .reconfig_req(reconfig_req), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Bit order: 0 ext, 1 stat, 2 core, 3 crc, 4 wd.
    task automatic drive_src(input logic [4:0] s);
        ext_reset_req = s[0];
        stat_err      = s[1];
        core_reload   = s[2];
        crc_err       = s[3];
        wd_timeout    = s[4];
    endtask

    function automatic int winner(input logic [4:0] s);
        if (s[0]) return 0;
        if (s[3]) return 3;
        if (s[1]) return 1;
        if (s[4]) return 4;
        return 2;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctrl", int'(ctrl_reg), 0);
        chk("R1 status", int'(status_reg), 0);
        chk("R1 image", int'(image_sel), 0);
        chk("R1 req", int'(reconfig_req), 0);
        chk("R1 busy", int'(busy), 0);

        for (int m = 0; m < 2; m++) begin
            // No source: nothing happens.
            app_mode = m[0];
            drive_src(5'd0);
            upd_reg = 8'hC3;
            @(negedge clk);
            @(negedge clk);
            chk("R6 idle busy", int'(busy), 0);
            chk("R6 idle req", int'(reconfig_req), 0);

            for (int c = 1; c < 32; c++) begin
                int w;
                int exp_ctrl;
                int exp_img;
                int req_cnt;
                int busy_cnt;
                logic [CW-1:0] u;
                w = winner(5'(c));
                u = CW'(c * 37 + m * 101 + 5);
                exp_ctrl = (w == 2) ? int'(u) : 0;
                exp_img  = (w == 2 && m == 0) ? 1 : 0;

                app_mode = m[0];
                upd_reg  = u;
                drive_src(5'(c));
                @(negedge clk);
                // Acceptance edge passed.
                chk("R4 R5 status", int'(status_reg), 1 << w);
                if (w == 2) chk("R3 ctrl copy", int'(ctrl_reg), exp_ctrl);
                else        chk("R2 ctrl clear", int'(ctrl_reg), exp_ctrl);
                chk("R6 busy at accept", int'(busy), 1);
                chk("R6 req not yet", int'(reconfig_req), 0);
                busy_cnt = 1;
                req_cnt  = 0;
                // Interfere while busy.
                drive_src(5'h1F);
                upd_reg  = ~u;
                app_mode = ~m[0];
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (!busy) begin
                        drive_src(5'd0);
                        break;
                    end
                    busy_cnt++;
                    if (reconfig_req) begin
                        req_cnt++;
                        chk("R10 image", int'(image_sel), exp_img);
                    end
                    chk("R9 status hold", int'(status_reg), 1 << w);
                    chk("R9 ctrl hold", int'(ctrl_reg), exp_ctrl);
                end
                chk("R7 pulse width", req_cnt, PC);
                chk("R8 busy length", busy_cnt, PC + 1);
                chk("R9 status after", int'(status_reg), 1 << w);
                chk("R9 ctrl after", int'(ctrl_reg), exp_ctrl);
                @(negedge clk);
                chk("R8 idle after", int'(busy), 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule